// File: doc/BRIEF.md
# G3 Hibernation Delay Timer

This block decides when a platform that is switched off and running from its battery has been idle long enough to drop into deep hibernation. It counts whole seconds, from a 1 Hz tick, while the platform sits in the fully-off (G3) state. When the count goes past a programmable delay, it raises a one-cycle hibernate request. The delay defaults to one hour and software can change it at any time through a simple write port.

The count starts again whenever the platform enters G3, and whenever external power is pulled while the platform is in G3. The count is cleared whenever the platform is outside G3. While external power is present the request is held off completely. Once external power goes away, the request is evaluated again against the count.

The request is issued at most once per G3 visit. The count saturates instead of wrapping. A remaining-seconds output reports the delay minus the elapsed count, clamped at zero, so firmware can show how long is left.

Top module: `hib_delay_timer`

## Requirements
- R1: After a synchronous active-low reset, the delay equals parameter DEFAULT_DELAY (3600 by default), the elapsed count is 0, hib_req is 0 and remain_sec equals the delay.
- R2: A cycle with cfg_wr_en high loads cfg_wr_data into the delay, and remain_sec reflects the new delay from the following cycle.
- R3: In a cycle with in_g3 high, sec_tick high and no restart pulse, the elapsed count rises by one on the clock edge. remain_sec then equals delay minus elapsed.
- R4: A cycle with g3_enter high clears the elapsed count, even when sec_tick is high in the same cycle.
- R5: A cycle with ac_removed high while in_g3 is high clears the elapsed count.
- R6: While in_g3 is low, the elapsed count is held at 0, so remain_sec equals the delay, and hib_req stays 0.
- R7: hib_req is a single-cycle pulse. It is high in the cycle after the first cycle in which in_g3 is high, ext_pwr is low, no restart pulse is present and the elapsed count is strictly greater than the delay.
- R8: While ext_pwr is high, no hib_req is ever issued. The elapsed count keeps advancing.
- R9: After a request, no further request is issued until a new G3 visit starts, either through g3_enter or through in_g3 going low and then high again. An ac_removed pulse does not re-arm the request.
- R10: The elapsed count saturates at 2^CNT_W-1 instead of wrapping. remain_sec clamps at 0 once elapsed reaches or exceeds the delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| g3_enter | input | 1 | One-cycle pulse when the platform enters G3 |
| ext_pwr | input | 1 | High while external power is present |
| ac_removed | input | 1 | One-cycle pulse when external power is removed |
| in_g3 | input | 1 | High while the platform is in G3 |
| cfg_wr_en | input | 1 | Write strobe for the delay |
| cfg_wr_data | input | CNT_W | New delay in seconds |
| hib_req | output | 1 | One-cycle hibernate request |
| remain_sec | output | CNT_W | Seconds left before a request, clamped at 0 |

## Verification
The bench builds the timer with CNT_W set to 6 and DEFAULT_DELAY set to 5. With these values, the expiry and the default delay are only a handful of ticks away, and the 63-second saturation point is reachable in under a hundred ticks. That small width also makes it possible to program the delay to the saturation value itself. In that case the count can never exceed the delay, so no request may fire, and the bench checks this. A behavioural model with integer state is compared against hib_req and remain_sec on every clock.

// File: rtl/hib_timer_pkg.sv
// Package: shared types for the hibernation delay timer.
// Assumes: restart pulses are one cycle wide and arrive synchronous to clk.
package hib_timer_pkg;

    // Reason the elapsed count is restarted in a given cycle.
    typedef enum logic [1:0] {
        RST_NONE   = 2'd0,
        RST_LEAVE  = 2'd1,
        RST_ENTRY  = 2'd2,
        RST_ACLOSS = 2'd3
    } restart_e;

    // Picks the restart reason; being out of G3 dominates, then entry, then AC loss.
    function automatic restart_e pick_restart(input logic in_g3,
                                              input logic g3_enter,
                                              input logic ac_removed);
        restart_e r;
        if (!in_g3)          r = RST_LEAVE;
        else if (g3_enter)   r = RST_ENTRY;
        else if (ac_removed) r = RST_ACLOSS;
        else                 r = RST_NONE;
        return r;
    endfunction

endpackage

// File: rtl/hib_delay_reg.sv
// Module: holds the programmable hibernation delay in seconds.
// Assumes: a write takes effect on the clock edge of the strobe cycle.
module hib_delay_reg #(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned DEFAULT_DELAY = 3600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] delay
);
    localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(DEFAULT_DELAY);

    // Load default at reset, otherwise take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     delay <= DEF_VAL;
        else if (wr_en) delay <= wr_data;
    end

    // R2
    wr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (delay == $past(wr_data)));

    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (delay == DEF_VAL));
endmodule

// File: rtl/hib_elapsed_ctr.sv
// Module: saturating seconds counter that measures time spent in G3.
// Assumes: clr has priority over tick; the count never wraps.
module hib_elapsed_ctr #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

    logic at_max;
    assign at_max = (count == MAX_VAL);

    // Clear on restart, otherwise advance once per tick until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (clr)              count <= '0;
        else if (tick && !at_max)  count <= count + 1'b1;
    end

    // R4 R5 R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && at_max) |=> (count == MAX_VAL));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick && !at_max) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/hib_fire_ctl.sv
// Module: compares elapsed time with the delay, issues the one-shot request
// and computes the remaining seconds.
// Assumes: restart reason is decoded upstream; request is registered.
module hib_fire_ctl
    import hib_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  restart_e         restart,
    input  logic             ext_pwr,
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] delay,
    output logic             hib_req,
    output logic [CNT_W-1:0] remain_sec
);
    logic fired;
    logic fire;
    logic rearm;

    // Fire only on battery, inside G3, without restart, once the delay is exceeded.
    assign fire  = (restart == RST_NONE) && !ext_pwr && !fired && (elapsed > delay);
    // A new G3 visit (leave or fresh entry) re-arms; AC loss does not.
    assign rearm = (restart == RST_LEAVE) || (restart == RST_ENTRY);

    // Track whether this G3 visit has already produced its request.
    always_ff @(posedge clk) begin
        if (!rst_n)     fired <= 1'b0;
        else if (rearm) fired <= 1'b0;
        else if (fire)  fired <= 1'b1;
    end

    // Register the request so it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) hib_req <= 1'b0;
        else        hib_req <= fire;
    end

    // Remaining seconds, clamped at zero.
    always_comb begin
        if (elapsed >= delay) remain_sec = '0;
        else                  remain_sec = delay - elapsed;
    end

    // R7
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hib_req |=> !hib_req);

    // R8
    ext_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pwr |=> !hib_req);

    // R6
    out_g3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart == RST_LEAVE) |=> !hib_req);

    // R9
    once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hib_req && restart == RST_NONE) |=> !hib_req);

    // R10
    remain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_sec <= delay));
endmodule

// File: rtl/hib_delay_timer.sv
// Module: top of the G3 hibernation delay timer.
// Assumes: all inputs are synchronous to clk; pulses are one cycle wide.
module hib_delay_timer
    import hib_timer_pkg::*;
#(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned DEFAULT_DELAY = 3600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             g3_enter,
    input  logic             ext_pwr,
    input  logic             ac_removed,
    input  logic             in_g3,
    input  logic             cfg_wr_en,
    input  logic [CNT_W-1:0] cfg_wr_data,
    output logic             hib_req,
    output logic [CNT_W-1:0] remain_sec
);
    restart_e         restart;
    logic             ctr_clr;
    logic [CNT_W-1:0] delay;
    logic [CNT_W-1:0] elapsed;

    // Decode the restart reason for this cycle.
    always_comb begin
        restart = pick_restart(in_g3, g3_enter, ac_removed);
        ctr_clr = (restart != RST_NONE);
    end

    hib_delay_reg #(
        .CNT_W         (CNT_W),
        .DEFAULT_DELAY (DEFAULT_DELAY)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .delay   (delay)
    );

    hib_elapsed_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .tick  (sec_tick),
        .count (elapsed)
    );

    hib_fire_ctl #(
        .CNT_W (CNT_W)
    ) u_fire (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .ext_pwr    (ext_pwr),
        .elapsed    (elapsed),
        .delay      (delay),
        .hib_req    (hib_req),
        .remain_sec (remain_sec)
    );

    // R4
    entry_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_g3 && g3_enter) |=> (remain_sec == delay || $past(cfg_wr_en)));
endmodule

// File: tb/sim_hib_delay_timer.sv
module sim_hib_delay_timer;
    localparam int W   = 6;
    localparam int DEF = 5;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sec_tick = 1'b0, g3_enter = 1'b0, ext_pwr = 1'b0;
    logic         ac_removed = 1'b0, in_g3 = 1'b0, cfg_wr_en = 1'b0;
    logic [W-1:0] cfg_wr_data = '0;
    logic         hib_req;
    logic [W-1:0] remain_sec;

    int errors = 0, checks = 0, req_count = 0, cycles = 0;
    int m_delay = DEF, m_el = 0, m_fired = 0, m_req = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hib_delay_timer #(.CNT_W(W), .DEFAULT_DELAY(DEF)) u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .g3_enter(g3_enter),
        .ext_pwr(ext_pwr), .ac_removed(ac_removed), .in_g3(in_g3),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .hib_req(hib_req), .remain_sec(remain_sec));

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        int fire;
        if (!rst_n) begin
            m_delay = DEF; m_el = 0; m_fired = 0; m_req = 0;
        end else begin
            fire = (in_g3 && !g3_enter && !ac_removed && !ext_pwr &&
                    !m_fired && (m_el > m_delay)) ? 1 : 0;
            m_req = fire;
            if (!in_g3 || g3_enter) m_fired = 0;
            else if (fire != 0)     m_fired = 1;
            if (!in_g3 || g3_enter || ac_removed) m_el = 0;
            else if (sec_tick && m_el < MAXV)     m_el = m_el + 1;
            if (cfg_wr_en) m_delay = int'(cfg_wr_data);
        end
    end

    function automatic int model_remain();
        return (m_el >= m_delay) ? 0 : m_delay - m_el;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare the design with the model on every clock, away from the edge.
    always @(negedge clk) begin
        cycles++;
        if (hib_req) req_count++;
        if (rst_n && !done) begin
            check("R7 R8 request vs model", int'(hib_req), m_req);
            check("R3 R10 remain vs model", int'(remain_sec), model_remain());
        end
    end

    // Watchdog.
    initial begin
        while (cycles < 100000 && !done) @(negedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; @(negedge clk);
            sec_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_enter();
        g3_enter = 1'b1; @(negedge clk); g3_enter = 1'b0;
    endtask

    task automatic write_delay(input int v);
        cfg_wr_data = W'(v); cfg_wr_en = 1'b1; @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset remain", int'(remain_sec), DEF);
        check("R1 reset request", int'(hib_req), 0);

        // Enter G3 and count.
        in_g3 = 1'b1; pulse_enter();
        ticks(3);
        check("R3 remain after 3 ticks", int'(remain_sec), DEF - 3);

        // AC loss restarts the count.
        ac_removed = 1'b1; @(negedge clk); ac_removed = 1'b0;
        check("R5 ac removal restarts", int'(remain_sec), DEF);

        // On external power: count runs but nothing fires.
        ext_pwr = 1'b1;
        ticks(10);
        idle(3);
        check("R8 no request on external power", req_count, 0);
        check("R10 remain clamps at zero", int'(remain_sec), 0);

        // Back on battery: exactly one request.
        ext_pwr = 1'b0;
        idle(4);
        check("R7 request after expiry", req_count, 1);
        ticks(4);
        idle(4);
        check("R9 no second request", req_count, 1);

        // Entry together with a tick clears; re-arms.
        sec_tick = 1'b1; g3_enter = 1'b1; @(negedge clk);
        sec_tick = 1'b0; g3_enter = 1'b0;
        check("R4 entry beats tick", int'(remain_sec), DEF);
        ticks(DEF);
        idle(3);
        check("R7 not yet at equal", req_count, 1);
        ticks(1);
        idle(2);
        check("R9 re-armed by entry", req_count, 2);

        // Leave G3: count held at zero, no request.
        in_g3 = 1'b0;
        ticks(10);
        check("R6 out of G3 remain", int'(remain_sec), DEF);
        check("R6 out of G3 no request", req_count, 2);

        // Reprogram the delay.
        write_delay(20);
        check("R2 new delay visible", int'(remain_sec), 20);
        in_g3 = 1'b1;
        ticks(21);
        idle(3);
        check("R2 R9 request with new delay", req_count, 3);

        // Delay at the saturation value never fires.
        write_delay(MAXV);
        pulse_enter();
        ticks(MAXV + 10);
        idle(3);
        check("R10 saturated remain", int'(remain_sec), 0);
        check("R10 no request at saturation", req_count, 3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule